// File: doc/BRIEF.md
# Grouped Sample-Rate Divider

This block generates the sample strobes for six converter channels. The channels are split into two groups of three, and each group counts pulses from one source. The source is either of two internal rate generators or an external clock. All three arrive as single-cycle tick enables in the core clock domain. A group first divides its source ticks by a fixed prescale of 128 to form a base rate. Each channel then divides that base rate by its own integer from 1 to 32 and emits a one-cycle strobe on every wrap.

Each group can be realigned by a software request, or by the external sync input when the group is set to follow it. A realignment clears the group's prescaler and all of its channel counters together. Channels whose divisors are related therefore keep a fixed phase to one another. A sync output and a clock output let a second board follow this one. Divisor and source changes wait for a wrap or a sync, so the block never produces a short sample period.

Top module: `grouped_rate_divider`

## Requirements
- R1: While `rstN` is low, `sampleStrobe`, `syncOut` and `clkOut` are all 0. The first cycle after reset acts as a sync for both groups, loading their current source and divisor settings.
- R2: Channels 0 to 2 belong to group 0 and channels 3 to 5 to group 1. Group g takes its source code from `groupSrcSel[2g+1:2g]`: 0 is rate generator A, 1 is rate generator B, 2 is the external clock, and 3 stops the group so that it produces no strobes.
- R3: A group forms one base tick from every 128 ticks of its active source. Counting starts from the cycle after a sync, and a source tick in the sync cycle itself is not counted.
- R4: Channel c reads its divisor from `chanDivField[5c+4:5c]`, which holds N-1. The channel strobes for one cycle on every Nth base tick after a sync, in the cycle after the base tick that completes the count.
- R5: A sync of group g clears that group's prescaler and channel counters only. A sync comes from `swSyncReq[g]`, or from `extSyncIn` when `extSyncEnable[g]` is 1. The other group keeps its phase.
- R6: A new divisor value takes effect only at the channel's next wrap or at a group sync. The period that is running when the value changes completes with the old divisor.
- R7: A new source code takes effect only when the group's prescaler wraps or at a group sync. A group whose active source is the stopped code changes only at a sync.
- R8: `syncOut` is 1 in the cycle after any `swSyncReq` bit or `extSyncIn` is 1, and 0 otherwise.
- R9: `clkOut` is a copy of the tick selected by `clkOutSel`, delayed by one register stage. The selector uses the R2 coding, and code 3 holds `clkOut` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| genTickA | input | 1 | Tick enable from internal rate generator A |
| genTickB | input | 1 | Tick enable from internal rate generator B |
| extClkTick | input | 1 | Tick enable from the external clock input |
| groupSrcSel | input | 4 | Source code per group, 2 bits each |
| chanDivField | input | 30 | Divisor minus one per channel, 5 bits each |
| swSyncReq | input | 2 | Software sync request per group |
| extSyncIn | input | 1 | External sync pulse |
| extSyncEnable | input | 2 | Per-group enable for following the external sync |
| clkOutSel | input | 2 | Source code for the clock output |
| sampleStrobe | output | 6 | One-cycle sample enable per channel |
| syncOut | output | 1 | Sync pulse toward a chained board |
| clkOut | output | 1 | Clock tick toward a chained board |

## Verification
The bench predicts the exact cycle of every strobe from the sync cycle, the source tick pattern and each divisor. A prescaler that counts the sync-cycle tick, or that is off by one, moves every strobe by whole source periods. A divisor written in the middle of a period must finish the old period first; a design that loads it at once gives a short period. A source set to stop must still let the prescaler finish its current count, and an external sync aimed at one group must leave the other group's strobe cadence unchanged. A design that shares sync or prescaler state between the groups fails these checks.

// File: rtl/rate_div_pkg.sv
`timescale 1ns/1ps
package rate_div_pkg;
  localparam int DEF_GROUPS       = 2;
  localparam int DEF_CH_PER_GROUP = 3;
  localparam int DEF_PREDIV       = 128;
  localparam int DEF_DIV_W        = 5;

  typedef enum logic [1:0] {
    SRC_GEN_A = 2'd0,
    SRC_GEN_B = 2'd1,
    SRC_EXT   = 2'd2,
    SRC_OFF   = 2'd3
  } srcSel_e;

  // per-group strobes from control to datapath
  typedef struct packed {
    logic sync;
    logic baseTick;
  } grpStrobe_t;
endpackage

// File: rtl/rate_grp_ctrl.sv
`timescale 1ns/1ps
module rate_grp_ctrl
  import rate_div_pkg::*;
#(
  parameter int GROUPS = DEF_GROUPS,
  parameter int PREDIV = DEF_PREDIV
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  genTickA,
  input  logic                  genTickB,
  input  logic                  extClkTick,
  input  logic [2*GROUPS-1:0]   groupSrcSel,
  input  logic [GROUPS-1:0]     swSyncReq,
  input  logic                  extSyncIn,
  input  logic [GROUPS-1:0]     extSyncEnable,
  input  logic [1:0]            clkOutSel,
  output grpStrobe_t [GROUPS-1:0] grpStb,
  output logic                  syncOut,
  output logic                  clkOut
);
  localparam int PRE_W = $clog2(PREDIV);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PREDIV - 1);

  function automatic logic pickTick(srcSel_e s, logic a, logic b, logic e);
    case (s)
      SRC_GEN_A: return a;
      SRC_GEN_B: return b;
      SRC_EXT:   return e;
      default:   return 1'b0;
    endcase
  endfunction

  // implicit sync in the first cycle after reset
  logic initSync;
  always_ff @(posedge clk) begin
    if (!rstN) initSync <= 1'b1;
    else       initSync <= 1'b0;
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    srcSel_e          activeSrc;
    srcSel_e          reqSrc;
    logic [PRE_W-1:0] preCnt;
    logic             selTick;
    logic             grpSync;
    logic             preWrap;

    always_comb begin
      reqSrc  = srcSel_e'(groupSrcSel[2*g +: 2]);
      grpSync = initSync | swSyncReq[g] | (extSyncEnable[g] & extSyncIn);
      selTick = pickTick(activeSrc, genTickA, genTickB, extClkTick);
      preWrap = selTick && (preCnt == PRE_LAST);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        activeSrc <= SRC_OFF;
        preCnt    <= '0;
      end else if (grpSync) begin
        activeSrc <= reqSrc;
        preCnt    <= '0;
      end else if (selTick) begin
        if (preWrap) begin
          preCnt    <= '0;
          activeSrc <= reqSrc;
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end
    end

    assign grpStb[g] = {grpSync, preWrap & ~grpSync};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncOut <= 1'b0;
      clkOut  <= 1'b0;
    end else begin
      syncOut <= (|swSyncReq) | extSyncIn;
      clkOut  <= pickTick(srcSel_e'(clkOutSel), genTickA, genTickB, extClkTick);
    end
  end
endmodule

// File: rtl/rate_chan_dp.sv
`timescale 1ns/1ps
module rate_chan_dp
  import rate_div_pkg::*;
#(
  parameter int GROUPS       = DEF_GROUPS,
  parameter int CH_PER_GROUP = DEF_CH_PER_GROUP,
  parameter int DIV_W        = DEF_DIV_W,
  localparam int NUM_CH      = GROUPS * CH_PER_GROUP
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  grpStrobe_t [GROUPS-1:0] grpStb,
  input  logic [DIV_W*NUM_CH-1:0] chanDivField,
  output logic [NUM_CH-1:0]       sampleStrobe
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int GRP = c / CH_PER_GROUP;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] activeDiv;
    logic [DIV_W-1:0] reqDiv;
    logic             wrapNow;
    logic             strobeQ;

    always_comb begin
      reqDiv  = chanDivField[c*DIV_W +: DIV_W];
      wrapNow = grpStb[GRP].baseTick && (cnt == activeDiv);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt       <= '0;
        activeDiv <= '0;
        strobeQ   <= 1'b0;
      end else begin
        strobeQ <= wrapNow;
        if (grpStb[GRP].sync) begin
          cnt       <= '0;
          activeDiv <= reqDiv;
        end else if (grpStb[GRP].baseTick) begin
          if (wrapNow) begin
            cnt       <= '0;
            activeDiv <= reqDiv;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end

    assign sampleStrobe[c] = strobeQ;
  end
endmodule

// File: rtl/grouped_rate_divider.sv
`timescale 1ns/1ps
module grouped_rate_divider
  import rate_div_pkg::*;
#(
  parameter int GROUPS       = DEF_GROUPS,
  parameter int CH_PER_GROUP = DEF_CH_PER_GROUP,
  parameter int PREDIV       = DEF_PREDIV,
  parameter int DIV_W        = DEF_DIV_W,
  localparam int NUM_CH      = GROUPS * CH_PER_GROUP
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    genTickA,
  input  logic                    genTickB,
  input  logic                    extClkTick,
  input  logic [2*GROUPS-1:0]     groupSrcSel,
  input  logic [DIV_W*NUM_CH-1:0] chanDivField,
  input  logic [GROUPS-1:0]       swSyncReq,
  input  logic                    extSyncIn,
  input  logic [GROUPS-1:0]       extSyncEnable,
  input  logic [1:0]              clkOutSel,
  output logic [NUM_CH-1:0]       sampleStrobe,
  output logic                    syncOut,
  output logic                    clkOut
);
  grpStrobe_t [GROUPS-1:0] grpStb;

  rate_grp_ctrl #(.GROUPS(GROUPS), .PREDIV(PREDIV)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .genTickA      (genTickA),
    .genTickB      (genTickB),
    .extClkTick    (extClkTick),
    .groupSrcSel   (groupSrcSel),
    .swSyncReq     (swSyncReq),
    .extSyncIn     (extSyncIn),
    .extSyncEnable (extSyncEnable),
    .clkOutSel     (clkOutSel),
    .grpStb        (grpStb),
    .syncOut       (syncOut),
    .clkOut        (clkOut)
  );

  rate_chan_dp #(.GROUPS(GROUPS), .CH_PER_GROUP(CH_PER_GROUP), .DIV_W(DIV_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .grpStb       (grpStb),
    .chanDivField (chanDivField),
    .sampleStrobe (sampleStrobe)
  );
endmodule

// File: rtl/rate_div_chk.sv
`timescale 1ns/1ps
module rate_div_chk
  import rate_div_pkg::*;
#(
  parameter int GROUPS       = DEF_GROUPS,
  parameter int CH_PER_GROUP = DEF_CH_PER_GROUP,
  localparam int NUM_CH      = GROUPS * CH_PER_GROUP
) (
  input logic              clk,
  input logic              rstN,
  input logic              genTickA,
  input logic              extClkTick,
  input logic [GROUPS-1:0] swSyncReq,
  input logic              extSyncIn,
  input logic [1:0]        clkOutSel,
  input logic [NUM_CH-1:0] sampleStrobe,
  input logic              syncOut,
  input logic              clkOut
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    // R4
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
      sampleStrobe[c] |=> !sampleStrobe[c]);
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_group
    // R5
    sync_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      swSyncReq[g] |=> (sampleStrobe[g*CH_PER_GROUP +: CH_PER_GROUP] == '0));
  end

  // R8
  sync_out_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|swSyncReq) || extSyncIn) |=> syncOut);

  // R8
  sync_out_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(|swSyncReq) && !extSyncIn) |=> !syncOut);

  // R9
  clk_out_gen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkOutSel == 2'd0 && genTickA) |=> clkOut);

  // R9
  clk_out_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkOutSel == 2'd2) |=> (clkOut == $past(extClkTick)));

  // R9
  clk_out_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkOutSel == 2'd3) |=> !clkOut);
endmodule

bind grouped_rate_divider rate_div_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .genTickA     (genTickA),
  .extClkTick   (extClkTick),
  .swSyncReq    (swSyncReq),
  .extSyncIn    (extSyncIn),
  .clkOutSel    (clkOutSel),
  .sampleStrobe (sampleStrobe),
  .syncOut      (syncOut),
  .clkOut       (clkOut)
);

// File: tb/grouped_rate_divider_bench.sv
`timescale 1ns/1ps
module grouped_rate_divider_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        genTickA = 1'b0, genTickB = 1'b0, extClkTick = 1'b0;
  logic [3:0]  groupSrcSel = 4'hF;
  logic [29:0] chanDivField = '0;
  logic [1:0]  swSyncReq = '0;
  logic        extSyncIn = 1'b0;
  logic [1:0]  extSyncEnable = '0;
  logic [1:0]  clkOutSel = '0;
  logic [5:0]  sampleStrobe;
  logic        syncOut, clkOut;

  grouped_rate_divider u_grouped_rate_divider (
    .clk(clk), .rstN(rstN), .genTickA(genTickA), .genTickB(genTickB),
    .extClkTick(extClkTick), .groupSrcSel(groupSrcSel), .chanDivField(chanDivField),
    .swSyncReq(swSyncReq), .extSyncIn(extSyncIn), .extSyncEnable(extSyncEnable),
    .clkOutSel(clkOutSel), .sampleStrobe(sampleStrobe), .syncOut(syncOut), .clkOut(clkOut)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checkCnt = 0, failCnt = 0;
  int expQ [6][$];
  int strobeCnt [6];
  int winLo = 0, winHi = 0;
  bit winOn = 1'b0;
  string curReq = "R1";

  task automatic check(bit ok, string req, string what, int act, int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // source tick patterns: A every cycle, B on even cycles, external every 4th
  initial forever begin
    @(negedge clk);
    genTickA   = 1'b1;
    genTickB   = (cyc % 2 == 0);
    extClkTick = (cyc % 4 == 0);
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (winOn && cyc >= winLo && cyc <= winHi) begin
      for (int ch = 0; ch < 6; ch++) begin
        if (sampleStrobe[ch]) begin
          strobeCnt[ch]++;
          if (expQ[ch].size() > 0 && expQ[ch][0] == cyc) begin
            void'(expQ[ch].pop_front());
            check(1'b1, curReq, "strobe", 1, 1);
          end else begin
            check(1'b0, curReq, $sformatf("unexpected strobe ch%0d", ch), 1, 0);
          end
        end else if (expQ[ch].size() > 0 && expQ[ch][0] == cyc) begin
          void'(expQ[ch].pop_front());
          check(1'b0, curReq, $sformatf("missing strobe ch%0d", ch), 0, 1);
        end
      end
    end
  end

  task automatic openWindow(int lo, int hi, string req);
    for (int ch = 0; ch < 6; ch++) begin
      expQ[ch].delete();
      strobeCnt[ch] = 0;
    end
    winLo = lo; winHi = hi; curReq = req; winOn = 1'b1;
  endtask

  task automatic pushSeries(int ch, int first, int period, int hi);
    for (int t = first; t <= hi; t += period) expQ[ch].push_back(t);
  endtask

  task automatic closeWindow();
    while (cyc <= winHi) @(negedge clk);
    for (int ch = 0; ch < 6; ch++)
      if (expQ[ch].size() > 0)
        check(1'b0, curReq, $sformatf("strobes never seen ch%0d", ch), 0, expQ[ch].size());
    winOn = 1'b0;
  endtask

  task automatic setDiv(int ch, int n);
    chanDivField[5*ch +: 5] = 5'(n - 1);
  endtask

  // pushes strobes for N-divisor channel of a group with base period bp from sync at v
  task automatic pushChan(int ch, int n, int v, int bp, int hi);
    pushSeries(ch, v + 1 + bp * n, bp * n, hi);
  endtask

  task automatic syncGroups(logic [1:0] mask, output int v);
    @(negedge clk);
    while (cyc % 4 != 0) @(negedge clk);
    v = cyc;
    swSyncReq = mask;
    @(negedge clk);
    swSyncReq = '0;
    check(syncOut == 1'b1, "R8", "syncOut after software sync", syncOut, 1);
  endtask

  task automatic runAll();
    int v, w, r;
    // R1: reset state
    groupSrcSel = {2'd3, 2'd0};
    setDiv(0, 1); setDiv(1, 2); setDiv(2, 1);
    setDiv(3, 1); setDiv(4, 1); setDiv(5, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(sampleStrobe == 6'd0, "R1", "strobes in reset", int'(sampleStrobe), 0);
      check(syncOut == 1'b0, "R1", "syncOut in reset", syncOut, 0);
      check(clkOut == 1'b0, "R1", "clkOut in reset", clkOut, 0);
    end
    @(negedge clk);
    r = cyc;
    rstN = 1'b1;
    // R1: implicit sync at release loads the settings
    openWindow(r + 1, r + 700, "R1");
    pushChan(0, 1, r, 128, r + 700);
    pushChan(1, 2, r, 128, r + 700);
    pushChan(2, 1, r, 128, r + 700);
    closeWindow();

    // R2 R3 R4 R5: both generators, harmonic divisors
    groupSrcSel = {2'd1, 2'd0};
    setDiv(0, 1); setDiv(1, 2); setDiv(2, 4);
    setDiv(3, 1); setDiv(4, 3); setDiv(5, 32);
    syncGroups(2'b11, v);
    openWindow(v + 1, v + 17000, "R4");
    pushChan(0, 1, v, 128, v + 17000);
    pushChan(1, 2, v, 128, v + 17000);
    pushChan(2, 4, v, 128, v + 17000);
    pushChan(3, 1, v, 256, v + 17000);
    pushChan(4, 3, v, 256, v + 17000);
    pushChan(5, 32, v, 256, v + 17000);
    closeWindow();

    // R6: divisor change mid-period completes the old period first
    groupSrcSel = {2'd3, 2'd0};
    setDiv(0, 1); setDiv(1, 2); setDiv(2, 4);
    syncGroups(2'b11, v);
    openWindow(v + 1, v + 2000, "R6");
    pushChan(0, 1, v, 128, v + 2000);
    pushChan(2, 4, v, 128, v + 2000);
    expQ[1].push_back(v + 257);
    expQ[1].push_back(v + 513);
    pushSeries(1, v + 897, 384, v + 2000);
    while (cyc < v + 300) @(negedge clk);
    setDiv(1, 3);
    closeWindow();

    // R7: switching to stopped waits for the prescaler wrap
    groupSrcSel = {2'd3, 2'd0};
    setDiv(0, 1); setDiv(1, 2); setDiv(2, 4);
    syncGroups(2'b11, v);
    openWindow(v + 1, v + 1500, "R7");
    expQ[0].push_back(v + 129);
    while (cyc < v + 64) @(negedge clk);
    groupSrcSel[1:0] = 2'd3;
    closeWindow();
    check(strobeCnt[1] == 0, "R7", "ch1 strobes after stop", strobeCnt[1], 0);
    check(strobeCnt[3] + strobeCnt[4] + strobeCnt[5] == 0, "R2", "stopped group strobes",
          strobeCnt[3] + strobeCnt[4] + strobeCnt[5], 0);

    // R5 R8: external sync realigns group 1 only
    groupSrcSel = {2'd0, 2'd0};
    extSyncEnable = 2'b10;
    setDiv(0, 1); setDiv(1, 2); setDiv(2, 4);
    setDiv(3, 1); setDiv(4, 2); setDiv(5, 4);
    syncGroups(2'b11, v);
    w = v + 200;
    openWindow(v + 1, v + 2000, "R5");
    pushChan(0, 1, v, 128, v + 2000);
    pushChan(1, 2, v, 128, v + 2000);
    pushChan(2, 4, v, 128, v + 2000);
    expQ[3].push_back(v + 129);
    pushChan(3, 1, w, 128, v + 2000);
    pushChan(4, 2, w, 128, v + 2000);
    pushChan(5, 4, w, 128, v + 2000);
    while (cyc < w) @(negedge clk);
    extSyncIn = 1'b1;
    @(negedge clk);
    extSyncIn = 1'b0;
    check(syncOut == 1'b1, "R8", "syncOut after external sync", syncOut, 1);
    @(negedge clk);
    check(syncOut == 1'b0, "R8", "syncOut idle", syncOut, 0);
    closeWindow();
    extSyncEnable = 2'b00;

    // R2 R3: external clock as source
    groupSrcSel = {2'd3, 2'd2};
    setDiv(0, 1); setDiv(1, 2); setDiv(2, 3);
    syncGroups(2'b11, v);
    openWindow(v + 1, v + 3200, "R3");
    pushChan(0, 1, v, 512, v + 3200);
    pushChan(1, 2, v, 512, v + 3200);
    pushChan(2, 3, v, 512, v + 3200);
    closeWindow();

    // R9: clock output follows the selected tick one cycle later
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      clkOutSel = 2'(s);
      for (int i = 0; i < 8; i++) begin
        int p;
        bit e;
        @(negedge clk);
        p = cyc - 1;
        e = (s == 0) ? 1'b1 : (s == 1) ? (p % 2 == 0) : (s == 2) ? (p % 4 == 0) : 1'b0;
        check(clkOut == e, "R9", $sformatf("clkOut sel %0d", s), clkOut, e);
      end
    end
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        checkCnt++;
        failCnt++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", 150000, 0);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule